// File: doc/BRIEF.md
# Streaming Positional Popcount Engine

This engine reports, for each of the eight bit positions of a byte, how many bytes in a memory array have that bit set. A single start pulse supplies a base byte address and a byte count. The engine then reads the array through a one-byte synchronous read port. It reads in blocks of at most eight bytes and puts each byte into its own lane of a 64-bit staging word. It then turns the 8x8 bit grid so that each output byte gathers one bit position from all lanes. It popcounts each of those eight bytes and adds each result into its own 64-bit counter.

The staging word is cleared before each block. The lanes of a short final block therefore hold zeros and add nothing to the counters. The counting step always handles all eight lanes. The remaining count drops by eight per block whatever the block's real size, and the loop ends once it is zero or below. When the last block is added, the engine raises done and holds the eight counters steady until the next start is accepted.

Top module: `pospop_engine`

## Requirements
- R1: When done rises, counter j (bits 64*j+63 down to 64*j of counts_o, j = 0..7) equals the number of bytes in the requested array whose bit j is 1.
- R2: Every read address lies in the window from base to base+len-1, and a request of len bytes issues exactly len reads.
- R3: The first read of a request uses the base address, and each later read uses the previous read address plus one, so the bytes are read in ascending order.
- R4: The bytes of a short final block come into a cleared staging word, so bytes from an earlier block are never counted twice.
- R5: busy_o is high for exactly len + 2*ceil(len/8) cycles after the start is accepted: for each block, one cycle per byte read, one cycle to take in the last byte, and one cycle to accumulate.
- R6: A start with len = 0 issues no reads. done_o goes high in the next cycle and all counters read zero.
- R7: Accepting a start clears all eight counters, so each result covers only its own request.
- R8: A start pulse while busy_o is high is ignored. The counts, the read addresses and the read count of the running request do not change.
- R9: done_o is low while busy_o is high. Once done_o is set, it stays high with stable counters until a new start is accepted.
- R10: After reset, busy_o, done_o and rd_req_o are low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| base_i | input | AW (16) | First byte address of the array |
| len_i | input | LW (16) | Number of bytes to count |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | AW (16) | Byte read address |
| rd_data_i | input | 8 | Read data, valid one cycle after the request |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | Counters are final |
| counts_o | output | 8*CW (512) | Eight bit-position counters, counter j at bits 64*j+63 down to 64*j |

## Verification
A start pulse can arrive in the same cycle as the engine's own block fetch or accumulate step. The engine must drop that pulse and leave the running request untouched. The bench provokes this by driving start high, with a different base and length, for several busy cycles of longer requests. It then judges the result by checking three things against the original request: the final counts, the exact read address sequence, and the busy length. A second collision is a start in the done state in the same cycle the counters are being held. That start must be taken, and it must clear the counters at once, which the bench shows by running a zero-length request after a nonzero one.

// File: rtl/pospop_pkg.sv
package pospop_pkg;
  localparam int unsigned LANES = 8;
  localparam int unsigned BYTEW = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ACC   = 2'd2,
    ST_DONE  = 2'd3
  } pp_state_e;
endpackage

// File: rtl/pospop_xpose.sv
module pospop_xpose #(
  parameter int unsigned N = 8
) (
  input  logic [N*N-1:0] grid_i,
  output logic [N*N-1:0] grid_o
);
  // bit j of lane i moves to bit i of row j
  for (genvar i = 0; i < N; i++) begin : g_lane
    for (genvar j = 0; j < N; j++) begin : g_bit
      assign grid_o[j*N + i] = grid_i[i*N + j];
    end
  end
endmodule

// File: rtl/pospop_lane_acc.sv
module pospop_lane_acc #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [N-1:0]  row_i,
  output logic [CW-1:0] acc_o
);
  localparam int unsigned PW = $clog2(N) + 1;

  logic [PW-1:0] pc;
  logic [CW-1:0] acc_q, acc_n;

  always_comb begin
    pc = '0;
    for (int b = 0; b < N; b++) pc = pc + PW'(row_i[b]);
  end

  always_comb begin
    acc_n = acc_q;
    if (clr_i)      acc_n = '0;
    else if (add_i) acc_n = acc_q + CW'(pc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/pospop_ctrl.sv
module pospop_ctrl
  import pospop_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [AW-1:0]          base_i,
  input  logic [LW-1:0]          len_i,
  input  logic [BYTEW-1:0]       rd_data_i,
  output logic                   rd_req_o,
  output logic [AW-1:0]          rd_addr_o,
  output logic [LANES*BYTEW-1:0] stage_o,
  output logic                   acc_clr_o,
  output logic                   acc_add_o,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam int unsigned RW  = LW + 1;
  localparam int unsigned IW  = $clog2(LANES) + 1;
  localparam int unsigned LIW = $clog2(LANES);
  localparam int unsigned SW  = LANES * BYTEW;
  localparam logic signed [RW-1:0] STEP = RW'(LANES);

  pp_state_e             st_q, st_n;
  logic signed [RW-1:0]  rem_q, rem_n, rem_sub;
  logic [IW-1:0]         iss_q, iss_n, blk;
  logic [AW-1:0]         addr_q, addr_n;
  logic                  rsp_v_q, rsp_v_n;
  logic [LIW-1:0]        lane_q, lane_n;
  logic [SW-1:0]         stage_q, stage_n;
  logic                  req, clr, add;

  always_comb begin
    st_n    = st_q;
    rem_n   = rem_q;
    iss_n   = iss_q;
    addr_n  = addr_q;
    lane_n  = lane_q;
    stage_n = stage_q;
    rsp_v_n = 1'b0;
    req     = 1'b0;
    clr     = 1'b0;
    add     = 1'b0;
    blk     = ($unsigned(rem_q) > $unsigned(STEP)) ? IW'(LANES) : rem_q[IW-1:0];
    rem_sub = rem_q - STEP;

    // one-cycle-latency return lands in the lane it was issued for
    if (rsp_v_q) stage_n[{lane_q, 3'b000} +: BYTEW] = rd_data_i;

    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          clr     = 1'b1;
          addr_n  = base_i;
          rem_n   = $signed({1'b0, len_i});
          iss_n   = '0;
          stage_n = '0;
          st_n    = (len_i == '0) ? ST_DONE : ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (iss_q < blk) begin
          req     = 1'b1;
          addr_n  = addr_q + 1'b1;
          iss_n   = iss_q + 1'b1;
          rsp_v_n = 1'b1;
          lane_n  = iss_q[LIW-1:0];
        end else if (rsp_v_q) begin
          st_n = ST_ACC;
        end
      end
      ST_ACC: begin
        add     = 1'b1;
        rem_n   = rem_sub;
        iss_n   = '0;
        stage_n = '0;
        st_n    = (rem_sub <= 0) ? ST_DONE : ST_FETCH;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rem_q   <= '0;
      iss_q   <= '0;
      addr_q  <= '0;
      rsp_v_q <= 1'b0;
      lane_q  <= '0;
      stage_q <= '0;
    end else begin
      st_q    <= st_n;
      rem_q   <= rem_n;
      iss_q   <= iss_n;
      addr_q  <= addr_n;
      rsp_v_q <= rsp_v_n;
      lane_q  <= lane_n;
      stage_q <= stage_n;
    end
  end

  assign rd_req_o  = req;
  assign rd_addr_o = addr_q;
  assign stage_o   = stage_q;
  assign acc_clr_o = clr;
  assign acc_add_o = add;
  assign busy_o    = (st_q == ST_FETCH) || (st_q == ST_ACC);
  assign done_o    = (st_q == ST_DONE);
endmodule

// File: rtl/pospop_engine.sv
module pospop_engine
  import pospop_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16,
  parameter int unsigned CW = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [AW-1:0]       base_i,
  input  logic [LW-1:0]       len_i,
  output logic                rd_req_o,
  output logic [AW-1:0]       rd_addr_o,
  input  logic [7:0]          rd_data_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [LANES*CW-1:0] counts_o
);
  localparam int unsigned SW = LANES * BYTEW;

  logic [SW-1:0] stage, rows;
  logic          acc_clr, acc_add;

  pospop_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .base_i    (base_i),
    .len_i     (len_i),
    .rd_data_i (rd_data_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .stage_o   (stage),
    .acc_clr_o (acc_clr),
    .acc_add_o (acc_add),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  pospop_xpose #(.N(LANES)) u_xpose (
    .grid_i (stage),
    .grid_o (rows)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_acc
    pospop_lane_acc #(.N(LANES), .CW(CW)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (acc_clr),
      .add_i (acc_add),
      .row_i (rows[j*LANES +: LANES]),
      .acc_o (counts_o[j*CW +: CW])
    );
  end
endmodule

// File: rtl/pospop_engine_chk.sv
module pospop_engine_chk
  import pospop_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned LW = 16,
  parameter int unsigned CW = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [AW-1:0]       base_i,
  input logic [LW-1:0]       len_i,
  input logic                rd_req_o,
  input logic [AW-1:0]       rd_addr_o,
  input logic [7:0]          rd_data_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [LANES*CW-1:0] counts_o
);
  logic [AW:0]   end_q;
  logic [AW-1:0] last_q;
  logic          seen_q;
  logic          take;

  assign take = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q  <= '0;
      last_q <= '0;
      seen_q <= 1'b0;
    end else begin
      if (take) begin
        end_q  <= {1'b0, base_i} + (AW+1)'(len_i);
        seen_q <= 1'b0;
      end else if (rd_req_o) begin
        last_q <= rd_addr_o;
        seen_q <= 1'b1;
      end
    end
  end

  a_r2_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> ({1'b0, rd_addr_o} < end_q));

  a_r3_post_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && seen_q) |-> (rd_addr_o == last_q + 1'b1));

  a_r6_empty_request: assert property (@(posedge clk) disable iff (!rst_n)
    (take && len_i == '0) |=> (done_o && !rd_req_o));

  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(counts_o)));

  a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  a_r2_no_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o);
endmodule

bind pospop_engine pospop_engine_chk #(.AW(AW), .LW(LW), .CW(CW)) u_chk (.*);

// File: tb/tb_pospop_engine.sv
module tb_pospop_engine;
  localparam int AW = 16;
  localparam int LW = 16;
  localparam int CW = 64;
  localparam int MEMN = 1024;

  logic            clk;
  logic            rst_n;
  logic            start_i;
  logic [AW-1:0]   base_i;
  logic [LW-1:0]   len_i;
  logic            rd_req_o;
  logic [AW-1:0]   rd_addr_o;
  logic [7:0]      rd_data_i;
  logic            busy_o;
  logic            done_o;
  logic [8*CW-1:0] counts_o;

  logic [7:0] mem [MEMN];
  int checks = 0;
  int errors = 0;
  int exp_addr, exp_end, nreads, addr_err;
  bit finished = 0;

  pospop_engine #(.AW(AW), .LW(LW), .CW(CW)) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_ff @(posedge clk) if (rd_req_o) rd_data_i <= mem[rd_addr_o[9:0]];

  // read monitor for R2/R3
  always @(negedge clk) begin
    if (rd_req_o) begin
      if (int'(rd_addr_o) != exp_addr || int'(rd_addr_o) >= exp_end) addr_err++;
      exp_addr++;
      nreads++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint model(input int base, input int len, input int j);
    longint s = 0;
    for (int k = 0; k < len; k++) s += longint'(mem[base + k][j]);
    return s;
  endfunction

  task automatic run(input int base, input int len, input bit inject, input string tag);
    int cyc;
    int expcyc;
    longint snap [8];
    exp_addr = base;
    exp_end  = base + len;
    nreads   = 0;
    addr_err = 0;
    @(negedge clk);
    start_i = 1'b1;
    base_i  = AW'(base);
    len_i   = LW'(len);
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (busy_o) begin
      cyc++;
      chk(!done_o, "R9", {tag, " done low while busy"}, longint'(done_o), 0);
      if (inject && cyc <= 3) begin
        start_i = 1'b1;  // R8: ignored while busy
        base_i  = AW'(base + 7);
        len_i   = LW'(3);
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    expcyc = len + 2 * ((len + 7) / 8);
    chk(done_o, "R1", {tag, " done"}, longint'(done_o), 1);
    chk(cyc == expcyc, "R5", {tag, " busy cycles"}, cyc, expcyc);
    chk(nreads == len, "R2", {tag, " read count"}, nreads, len);
    chk(addr_err == 0, "R3", {tag, " address sequence"}, addr_err, 0);
    for (int j = 0; j < 8; j++) begin
      snap[j] = longint'(counts_o[j*CW +: CW]);
      chk(snap[j] == model(base, len, j), inject ? "R8" : "R1",
          {tag, $sformatf(" count bit %0d", j)}, snap[j], model(base, len, j));
    end
    repeat (3) @(negedge clk);
    chk(done_o, "R9", {tag, " done held"}, longint'(done_o), 1);
    for (int j = 0; j < 8; j++)
      chk(longint'(counts_o[j*CW +: CW]) == snap[j], "R9", {tag, " counts stable"},
          longint'(counts_o[j*CW +: CW]), snap[j]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < MEMN; a++) mem[a] = 8'($urandom);
    start_i = 1'b0;
    base_i  = '0;
    len_i   = '0;
    exp_end = 0;
    exp_addr = 0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy_o && !done_o && !rd_req_o, "R10", "idle outputs",
        longint'({busy_o, done_o, rd_req_o}), 0);
    chk(counts_o == '0, "R10", "counters zero", longint'(counts_o[63:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(10, 8, 0, "full block");
    run(30, 1, 0, "single byte");
    run(50, 7, 0, "seven bytes");
    run(70, 9, 0, "nine bytes");
    run(120, 64, 0, "eight blocks");
    // R4: all-ones region, full block then partial block
    for (int a = 300; a < 320; a++) mem[a] = 8'hFF;
    run(300, 11, 0, "R4 ones partial");
    // R6 / R7: zero length right after a nonzero run
    run(400, 0, 0, "R6 R7 empty");
    chk(counts_o == '0, "R7", "cleared on start", longint'(counts_o[63:0]), 0);
    // one-hot lane pattern exercises the transpose
    for (int a = 500; a < 508; a++) mem[a] = 8'(1 << (a - 500));
    run(500, 8, 0, "one-hot lanes");
    run(600, 40, 1, "R8 start while busy");
    run(700, 23, 1, "R8 partial while busy");
    for (int t = 0; t < 20; t++) begin
      int len = int'($urandom_range(0, 100));
      int base = int'($urandom_range(0, MEMN - 1 - 100));
      run(base, len, (len >= 8) && t[0], $sformatf("random %0d", t));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule